// File: doc/BRIEF.md
# Half-Word Multiplexed Operand and Result Bus Port

This block sits between a narrow 16-bit shared bus and a three-stage 32-bit arithmetic pipeline. The bus runs on the fast clock. The pipeline advances once every two fast cycles, so one full 32-bit word crosses the bus in each pipeline slot. Every word travels as two half-words. The low half goes in the first cycle of a slot and the high half goes in the second. A slot state machine alternates between `SLOT_LO` and `SLOT_HI` and publishes the current slot on `slot_o`. The bus master uses that output to know which half the bus carries.

There are two operand registers, A and B, and each has its own load strobe. A word on the bus can go to A, to B or to both. A register that is not loaded keeps its value, so a constant operand is sent only once. Each operand has an assembly state machine with the states `ASM_EMPTY` and `ASM_LOW_HELD`:
- `ASM_EMPTY` moves to `ASM_LOW_HELD` when the low half arrives with its strobe.
- `ASM_LOW_HELD` commits the full word when the high half also carries the strobe, then returns to `ASM_EMPTY`.
- Every high slot returns the machine to `ASM_EMPTY`.

All bus inputs and strobes pass through input registers. The unload request is sampled with the high half of a slot. It then travels through the core pipeline as a tag beside that slot's sum. When a tagged sum leaves the pipeline, the unload state machine steps through `UNL_IDLE` → `UNL_LO` → `UNL_HI`:
- It drives the low half, then the high half, on registered outputs with the bus enable raised.
- From `UNL_HI` it goes straight back to `UNL_LO` if the next sum is also tagged. Otherwise it goes to `UNL_IDLE`.

A registered modulo-2^32 adder stands in for the arithmetic core.

Top module: `hbp_bus_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_oe` is 0, `bus_out` is 0 and `slot_o` is 0. Reset clears both operands to zero and discards every operation in flight.
- R2: `slot_o` alternates every fast cycle. 0 marks the low-half cycle and 1 marks the high-half cycle of a slot.
- R3: An operand is committed only when its strobe is high in both cycles of one slot. The committed word is {high half, low half}: bus bits [15:0] of the high cycle become word bits [31:16], and those of the low cycle become bits [15:0].
- R4: An operand whose strobe is low for a slot keeps its previous value. Later operations reuse that value.
- R5: A strobe present in only one of the two cycles of a slot leaves the committed operand unchanged. This holds for a low-only strobe and for a high-only strobe.
- R6: A slot whose low half is driven in cycle n shows the low half of A+B on `bus_out` in cycle n+9 and the high half in cycle n+10. A and B are the operand values after that slot's own commit.
- R7: `unload`, sampled in the high cycle of a slot, stays attached to that slot's result. `bus_oe` is 1 in exactly the two result cycles of tagged slots and 0 in every other cycle.
- R8: Whenever `bus_oe` is 0, `bus_out` is 0.
- R9: Operations in consecutive slots each produce their result with no gap, one word every two cycles.
- R10: The stand-in core computes A+B modulo 2^32 (the carry out of bit 31 is dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bus-rate) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Incoming half-word, low half then high half |
| ld_a | input | 1 | Load strobe for operand A, held for both cycles of a slot |
| ld_b | input | 1 | Load strobe for operand B, held for both cycles of a slot |
| unload | input | 1 | Result request, sampled in the high cycle of a slot |
| slot_o | output | 1 | Current slot half: 0 low, 1 high |
| bus_out | output | 16 | Outgoing result half-word, zero when not driven |
| bus_oe | output | 1 | Three-state enable for `bus_out` |

## Verification
The assertions assume the bus master follows `slot_o`. It starts every word in a low cycle and changes the strobes only at slot boundaries. Under that assumption, assembly and unload states stay locked to the slot phase. The bench waits until the upcoming cycle is a low cycle before each word, and drives all inputs on the falling edge. The one deliberate exception is a single-cycle strobe, used to show that a partial load is refused. Reset is applied once with a tagged result in flight, which confirms that nothing leaks out afterwards.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    // Which half-word the bus carries in the current fast cycle.
    typedef enum logic {
        SLOT_LO = 1'b0,
        SLOT_HI = 1'b1
    } slot_e;

    // Per-operand assembly progress.
    typedef enum logic {
        ASM_EMPTY    = 1'b0,
        ASM_LOW_HELD = 1'b1
    } asm_e;

    // Result unload sequencing.
    typedef enum logic [1:0] {
        UNL_IDLE = 2'd0,
        UNL_LO   = 2'd1,
        UNL_HI   = 2'd2
    } unl_e;

endpackage

// File: rtl/hbp_slot_fsm.sv
module hbp_slot_fsm
    import hbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    slot_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_LO: st_nx = SLOT_HI;
            SLOT_HI: st_nx = SLOT_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SLOT_LO;
        else        st <= st_nx;
    end

    assign slot = st;

    // R2: the half marker alternates every fast cycle
    a_r2_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_LO) |=> (st == SLOT_HI));
    a_r2_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_HI) |=> (st == SLOT_LO));

endmodule

// File: rtl/hbp_operand_asm.sv
module hbp_operand_asm
    import hbp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_e               slot_q,
    input  logic                ld_q,
    input  logic [HALF_W-1:0]   half_q,
    output logic [2*HALF_W-1:0] word_o
);

    localparam int WORD_W = 2 * HALF_W;

    asm_e              st, st_nx;
    logic [HALF_W-1:0] lo_hold;
    logic              take_lo;
    logic              commit;

    assign take_lo = (slot_q == SLOT_LO) && ld_q;
    assign commit  = (st == ASM_LOW_HELD) && (slot_q == SLOT_HI) && ld_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            ASM_EMPTY:    st_nx = take_lo ? ASM_LOW_HELD : ASM_EMPTY;
            ASM_LOW_HELD: st_nx = take_lo ? ASM_LOW_HELD : ASM_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ASM_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold <= '0;
            word_o  <= '0;
        end else begin
            if (take_lo) lo_hold <= half_q;
            if (commit)  word_o  <= {half_q, lo_hold};
        end
    end

    // R4: no strobe, no change to the committed word
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_q |=> $stable(word_o));
    // R5: a high-half strobe without a captured low half commits nothing
    a_r5_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == SLOT_HI) && ld_q && (st == ASM_EMPTY)) |=> $stable(word_o));
    // R3: after a commit the low bits are the half captured in the low cycle
    a_r3_low_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (word_o[HALF_W-1:0] == $past(lo_hold)));

    logic unused_w;
    assign unused_w = ^WORD_W;

endmodule

// File: rtl/hbp_core_stub.sv
module hbp_core_stub #(
    parameter int WORD_W = 32,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              tag_in,
    output logic [WORD_W-1:0] sum_o,
    output logic              tag_o
);

    localparam int LAST = STAGES - 1;

    logic [WORD_W-1:0] sum_pipe [STAGES];
    logic [STAGES-1:0] tag_pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) sum_pipe[s] <= '0;
            tag_pipe <= '0;
        end else if (en) begin
            sum_pipe[0] <= opa + opb;
            tag_pipe[0] <= tag_in;
            for (int s = 1; s < STAGES; s++) begin
                sum_pipe[s] <= sum_pipe[s-1];
                tag_pipe[s] <= tag_pipe[s-1];
            end
        end
    end

    assign sum_o = sum_pipe[LAST];
    assign tag_o = tag_pipe[LAST];

    // R9: the pipeline only moves on its slot enable
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sum_o) && $stable(tag_o)));

endmodule

// File: rtl/hbp_unload_seq.sv
module hbp_unload_seq
    import hbp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_e               slot_q,
    input  logic                tag,
    input  logic [2*HALF_W-1:0] result,
    output logic [HALF_W-1:0]   bus_out,
    output logic                bus_oe
);

    localparam int WORD_W = 2 * HALF_W;

    unl_e              st, st_nx;
    logic [WORD_W-1:0] hold, hold_nx;
    logic              start;

    assign start = (slot_q == SLOT_HI) && tag;

    always_comb begin
        st_nx   = st;
        hold_nx = hold;
        unique case (st)
            UNL_IDLE: st_nx = start ? UNL_LO : UNL_IDLE;
            UNL_LO:   st_nx = UNL_HI;
            UNL_HI:   st_nx = start ? UNL_LO : UNL_IDLE;
            default:  st_nx = UNL_IDLE;
        endcase
        if (start) hold_nx = result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= UNL_IDLE;
            hold <= '0;
        end else begin
            st   <= st_nx;
            hold <= hold_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            unique case (st_nx)
                UNL_LO: begin
                    bus_out <= hold_nx[HALF_W-1:0];
                    bus_oe  <= 1'b1;
                end
                UNL_HI: begin
                    bus_out <= hold_nx[WORD_W-1:HALF_W];
                    bus_oe  <= 1'b1;
                end
                default: begin
                    bus_out <= '0;
                    bus_oe  <= 1'b0;
                end
            endcase
        end
    end

    // R7: a low result half is always followed by its high half
    a_r7_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UNL_LO) |=> (st == UNL_HI));
    // R7: an untagged result in a high slot never enables the bus
    a_r7_no_tag_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == SLOT_HI) && !tag) |=> !bus_oe);
    // R2/R7: an idle sequencer in a low slot stays idle
    a_r7_idle_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == SLOT_LO) && (st == UNL_IDLE)) |=> (st == UNL_IDLE));

endmodule

// File: rtl/hbp_bus_port.sv
module hbp_bus_port
    import hbp_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int CORE_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] bus_in,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              unload,
    output logic              slot_o,
    output logic [HALF_W-1:0] bus_out,
    output logic              bus_oe
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int N_OPS  = 2;

    slot_e              slot;
    slot_e              slot_q;
    logic [HALF_W-1:0]  half_q;
    logic [N_OPS-1:0]   ld_q;
    logic               unl_q;
    logic               unl_hold;
    logic [WORD_W-1:0]  opnd [N_OPS];
    logic               core_en;
    logic [WORD_W-1:0]  core_sum;
    logic               core_tag;

    hbp_slot_fsm u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    // Input register stage: every bus input and strobe is captured first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            ld_q   <= '0;
            unl_q  <= 1'b0;
            slot_q <= SLOT_LO;
        end else begin
            half_q <= bus_in;
            ld_q   <= {ld_b, ld_a};
            unl_q  <= unload;
            slot_q <= slot;
        end
    end

    // The unload request belongs to the slot whose high half carries it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  unl_hold <= 1'b0;
        else if (slot_q == SLOT_HI)  unl_hold <= unl_q;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_opnd
        hbp_operand_asm #(.HALF_W(HALF_W)) u_asm (
            .clk    (clk),
            .rst_n  (rst_n),
            .slot_q (slot_q),
            .ld_q   (ld_q[g]),
            .half_q (half_q),
            .word_o (opnd[g])
        );
    end

    assign core_en = (slot_q == SLOT_LO);

    hbp_core_stub #(.WORD_W(WORD_W), .STAGES(CORE_STAGES)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (core_en),
        .opa    (opnd[0]),
        .opb    (opnd[1]),
        .tag_in (unl_hold),
        .sum_o  (core_sum),
        .tag_o  (core_tag)
    );

    hbp_unload_seq #(.HALF_W(HALF_W)) u_unload (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_q  (slot_q),
        .tag     (core_tag),
        .result  (core_sum),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    assign slot_o = (slot == SLOT_HI);

    // R8: an undriven bus carries zero
    a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
    // R7: the enable is raised only right after a tagged result reached the end
    a_r7_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(core_tag));

endmodule

// File: tb/hbp_bus_port_tb.sv
`timescale 1ns/1ps
module hbp_bus_port_tb;

    localparam int HALF_W = 16;
    localparam int LAT    = 9;
    localparam int SB     = 512;
    localparam int NV     = 11;

    // entry: [36:5] word, [4] ld_a, [3] ld_b, [2] unload, [1] A low-only, [0] B high-only
    localparam logic [36:0] VEC [NV] = '{
        {32'h0001_0002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'hAAAA_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0000_FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'h0000_0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'h5555_5555, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [HALF_W-1:0] bus_in = '0;
    logic              ld_a = 1'b0;
    logic              ld_b = 1'b0;
    logic              unload = 1'b0;
    logic              slot_o;
    logic [HALF_W-1:0] bus_out;
    logic              bus_oe;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;
    logic [31:0]       m_a = '0;
    logic [31:0]       m_b = '0;
    logic              exp_oe  [SB];
    logic [HALF_W-1:0] exp_dat [SB];

    always #4 clk = ~clk;

    hbp_bus_port u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (bus_in),
        .ld_a    (ld_a),
        .ld_b    (ld_b),
        .unload  (unload),
        .slot_o  (slot_o),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic clear_sb();
        for (int i = 0; i < SB; i++) begin
            exp_oe[i]  = 1'b0;
            exp_dat[i] = '0;
        end
    endtask

    // One fast cycle: check this cycle's outputs, then drive this cycle's inputs.
    task automatic tick(input logic [HALF_W-1:0] d, input logic la, input logic lb, input logic un);
        @(negedge clk);
        if (chk_en && cyc < SB) begin
            chk(bus_oe === exp_oe[cyc], "R7 enable", {31'd0, bus_oe}, {31'd0, exp_oe[cyc]});
            if (exp_oe[cyc])
                chk(bus_out === exp_dat[cyc], "R6 result half", {16'd0, bus_out}, {16'd0, exp_dat[cyc]});
            else
                chk(bus_out === '0, "R8 quiet bus", {16'd0, bus_out}, 32'd0);
        end
        bus_in = d; ld_a = la; ld_b = lb; unload = un;
        cyc++;
    endtask

    task automatic issue(input logic [31:0] w, input logic la, input logic lb, input logic un,
                         input logic a_lo_only, input logic b_hi_only);
        int c0;
        logic [31:0] s;
        if (slot_o == 1'b0) tick('0, 1'b0, 1'b0, 1'b0);
        c0 = cyc;
        tick(w[15:0], la, lb & ~b_hi_only, 1'b0);
        chk(slot_o === 1'b0, "R2 low cycle", {31'd0, slot_o}, 32'd0);
        tick(w[31:16], la & ~a_lo_only, lb, un);
        chk(slot_o === 1'b1, "R2 high cycle", {31'd0, slot_o}, 32'd1);
        // R3 R4 R5: model of operand commits
        if (la && !a_lo_only) m_a = w;
        if (lb && !b_hi_only) m_b = w;
        s = m_a + m_b;              // R10: wraps modulo 2^32
        if (un && c0 + LAT + 1 < SB) begin
            exp_oe[c0+LAT]    = 1'b1;
            exp_dat[c0+LAT]   = s[15:0];
            exp_oe[c0+LAT+1]  = 1'b1;
            exp_dat[c0+LAT+1] = s[31:16];
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0; chk_en = 1'b0;
        bus_in = '0; ld_a = 1'b0; ld_b = 1'b0; unload = 1'b0;
        @(negedge clk);
        // R1: outputs idle while reset is held
        chk(bus_oe === 1'b0, "R1 reset enable", {31'd0, bus_oe}, 32'd0);
        chk(bus_out === '0, "R1 reset data", {16'd0, bus_out}, 32'd0);
        chk(slot_o === 1'b0, "R1 reset slot", {31'd0, slot_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        m_a = '0; m_b = '0;
        clear_sb();
        cyc = 0; chk_en = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_sb();
        repeat (3) @(posedge clk);
        reset_check();
        // Vector table: R3 R4 R5 R6 R7 R9 R10 in back-to-back slots
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][36:5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        for (int i = 0; i < 14; i++) tick('0, 1'b0, 1'b0, 1'b0);

        // R1: reset with a tagged result still in the pipeline
        issue(32'h0F0F_0F0F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        tick('0, 1'b0, 1'b0, 1'b0);
        tick('0, 1'b0, 1'b0, 1'b0);
        reset_check();
        // R7: the flushed result must never appear
        for (int i = 0; i < 16; i++) tick('0, 1'b0, 1'b0, 1'b0);
        // R1: operands were cleared, so an unload with no loads returns zero
        issue(32'h1111_2222, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 14; i++) tick('0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule